// File: doc/BRIEF.md
# MOESI Snooping Line-State Controller

This block holds the coherence state of every line slot in one data cache of a small multi-core system, where each cache watches a shared broadcast snoop bus. Each cycle it can take one access from the local processor (read, write or eviction, together with the tag-compare hit result and the slot index) and one snooped transaction that another cache has placed on the bus (a read, or a write that claims ownership). It returns the state the local slot will hold after the cycle, the bus transaction the local access needs, whether this cache must drive data to the snooping requester, and whether an evicted line must be written back to memory.

The five-state protocol lets a dirty line be shared. A snooping reader of a dirty line receives data straight from this cache, and the line stays dirty here in the owner state instead of being flushed first. Clean shared lines are left to memory. Data arrays, tag comparison and victim choice are outside the block. Bus arbitration is reduced to a grant input. A local access that needs the bus holds its inputs until the cycle in which it is granted, and that is the cycle in which it completes.

Top module: `moesi_line_ctrl`

## Requirements
State codes: Invalid=0, Shared=1, Exclusive=2, Owned=3, Modified=4. Bus request codes: 0 none, 1 read, 2 read-for-ownership, 3 upgrade. Local op codes: 0 read, 1 write, 2 evict. Snoop op codes: 0 read, 1 write.
- R1: Reset sets every slot to Invalid (0) with all outputs low, so a later access that reports a tag hit still sees Invalid.
- R2: A local read to an Invalid slot or a tag miss drives bus request 1 with cpu_done low until bus_grant. In the granted cycle cpu_done is high and the slot becomes Exclusive (2) if bus_shared is low, or Shared (1) if it is high.
- R3: A local read hit on a valid slot completes in the same cycle with no bus request and no state change.
- R4: A local write hit on Exclusive becomes Modified with no bus request. A write hit on Modified stays Modified with no bus request.
- R5: A local write hit on Shared or Owned drives bus request 3 until granted, then the slot becomes Modified.
- R6: A local write miss, or a write to an Invalid slot, drives bus request 2 until granted, then the slot is installed as Modified.
- R7: A snooped read hitting Modified asserts snp_supply and moves the slot to Owned. A snooped read hitting Owned asserts snp_supply and leaves it Owned.
- R8: A snooped read hitting Exclusive moves the slot to Shared. A snooped read hitting Shared or Invalid leaves the slot unchanged. In all three cases snp_supply stays low.
- R9: A snooped write hitting a slot moves it to Invalid. snp_supply is asserted only if the slot was Modified or Owned.
- R10: A local evict hit asserts writeback_req only if the slot is Modified or Owned, and always leaves the slot Invalid. An evict with a tag miss changes nothing. Evict completes in the same cycle.
- R11: When a snoop and a local access name the same slot in one cycle, the snoop transition is applied first and the local access acts on the resulting state.
- R12: A snoop with snp_hit low leaves the slot state unchanged and keeps snp_supply low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Local access present |
| cpu_op | input | 2 | Local op: 0 read, 1 write, 2 evict |
| cpu_hit | input | 1 | Tag compare matched for the local access |
| cpu_idx | input | IDX_W | Slot index of the local access |
| snp_valid | input | 1 | Snooped transaction present |
| snp_op | input | 1 | Snoop op: 0 read, 1 write |
| snp_hit | input | 1 | Tag compare matched for the snoop |
| snp_idx | input | IDX_W | Slot index of the snoop |
| bus_grant | input | 1 | Bus granted to the pending local request |
| bus_shared | input | 1 | Another cache holds the line being filled |
| bus_req_op | output | 2 | Bus request: 0 none, 1 read, 2 read-for-ownership, 3 upgrade |
| cpu_done | output | 1 | Local access completes this cycle |
| writeback_req | output | 1 | Evicted slot is dirty and must be written back |
| snp_supply | output | 1 | This cache drives data to the snooping requester |
| cpu_state_nxt | output | 3 | State of slot cpu_idx after this cycle |

## Verification
The functions that can collide are a snooped transaction and a local access on the same slot in the same cycle. The bench drives both in one vector. Cases include a snooped read with a local write on an Exclusive slot, a snooped write arriving while an upgrade is still waiting for the grant, a snooped read with a local read on a Modified slot, and a snooped write with an eviction. Each case is judged by whether the local result follows the post-snoop state: the upgrade turning into a read-for-ownership, the eviction seeing an already-Invalid slot without write-back, and snp_supply still reflecting the pre-snoop dirty state.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

    typedef enum logic [2:0] {
        LS_INV = 3'd0,
        LS_SHR = 3'd1,
        LS_EXC = 3'd2,
        LS_OWN = 3'd3,
        LS_MOD = 3'd4
    } line_state_e;

    typedef enum logic [1:0] {
        BUS_NONE = 2'd0,
        BUS_RD   = 2'd1,
        BUS_RFO  = 2'd2,
        BUS_UPG  = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        CPU_RD    = 2'd0,
        CPU_WR    = 2'd1,
        CPU_EVICT = 2'd2,
        CPU_RSVD  = 2'd3
    } cpu_op_e;

    typedef enum logic {
        SNP_RD = 1'b0,
        SNP_WR = 1'b1
    } snp_op_e;

    typedef struct packed {
        line_state_e nxt;
        logic        supply;
    } snoop_res_t;

    typedef struct packed {
        line_state_e nxt;
        bus_op_e     req;
        logic        done;
        logic        wb;
    } local_res_t;

    function automatic logic is_dirty(line_state_e s);
        return (s == LS_MOD) || (s == LS_OWN);
    endfunction

endpackage

// File: rtl/moesi_snoop_stage.sv
module moesi_snoop_stage
    import moesi_pkg::*;
(
    input  logic        valid,
    input  logic        op,
    input  logic        hit,
    input  line_state_e cur,
    output snoop_res_t  res
);
    always_comb begin
        res.nxt    = cur;
        res.supply = 1'b0;
        if (valid && hit) begin
            res.supply = is_dirty(cur);
            if (snp_op_e'(op) == SNP_WR) begin
                res.nxt = LS_INV;
            end else begin
                case (cur)
                    LS_MOD:  res.nxt = LS_OWN;
                    LS_EXC:  res.nxt = LS_SHR;
                    default: res.nxt = cur;
                endcase
            end
        end
    end
endmodule

// File: rtl/moesi_local_stage.sv
module moesi_local_stage
    import moesi_pkg::*;
(
    input  logic        valid,
    input  logic [1:0]  op,
    input  logic        hit,
    input  line_state_e pre,
    input  logic        grant,
    input  logic        shared,
    output local_res_t  res
);
    logic miss;
    assign miss = !hit || (pre == LS_INV);

    always_comb begin
        res.nxt  = pre;
        res.req  = BUS_NONE;
        res.done = 1'b0;
        res.wb   = 1'b0;
        if (valid) begin
            case (cpu_op_e'(op))
                CPU_RD: begin
                    if (!miss) begin
                        res.done = 1'b1;
                    end else begin
                        res.req = BUS_RD;
                        if (grant) begin
                            res.done = 1'b1;
                            res.nxt  = shared ? LS_SHR : LS_EXC;
                        end
                    end
                end
                CPU_WR: begin
                    if (!miss && (pre == LS_MOD || pre == LS_EXC)) begin
                        res.done = 1'b1;
                        res.nxt  = LS_MOD;
                    end else begin
                        res.req = miss ? BUS_RFO : BUS_UPG;
                        if (grant) begin
                            res.done = 1'b1;
                            res.nxt  = LS_MOD;
                        end
                    end
                end
                CPU_EVICT: begin
                    res.done = 1'b1;
                    if (hit) begin
                        res.wb  = is_dirty(pre);
                        res.nxt = LS_INV;
                    end
                end
                default: begin
                    res.done = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
    import moesi_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_valid,
    input  logic [1:0]       cpu_op,
    input  logic             cpu_hit,
    input  logic [IDX_W-1:0] cpu_idx,
    input  logic             snp_valid,
    input  logic             snp_op,
    input  logic             snp_hit,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic             bus_grant,
    input  logic             bus_shared,
    output logic [1:0]       bus_req_op,
    output logic             cpu_done,
    output logic             writeback_req,
    output logic             snp_supply,
    output logic [2:0]       cpu_state_nxt
);
    line_state_e lines [LINES];
    line_state_e snp_cur;
    line_state_e cpu_pre;
    snoop_res_t  snp_res;
    local_res_t  loc_res;
    logic        same_slot;

    assign snp_cur   = lines[snp_idx];
    assign same_slot = snp_valid && (snp_idx == cpu_idx);
    // snoop result feeds the local stage first on a shared slot
    assign cpu_pre   = same_slot ? snp_res.nxt : lines[cpu_idx];

    moesi_snoop_stage u_snoop (
        .valid (snp_valid),
        .op    (snp_op),
        .hit   (snp_hit),
        .cur   (snp_cur),
        .res   (snp_res)
    );

    moesi_local_stage u_local (
        .valid  (cpu_valid),
        .op     (cpu_op),
        .hit    (cpu_hit),
        .pre    (cpu_pre),
        .grant  (bus_grant),
        .shared (bus_shared),
        .res    (loc_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) lines[i] <= LS_INV;
        end else begin
            if (snp_valid && snp_hit) lines[snp_idx] <= snp_res.nxt;
            if (cpu_valid)            lines[cpu_idx] <= loc_res.nxt;
        end
    end

    assign bus_req_op    = loc_res.req;
    assign cpu_done      = loc_res.done;
    assign writeback_req = loc_res.wb;
    assign snp_supply    = snp_res.supply;
    assign cpu_state_nxt = loc_res.nxt;

    AST_SNOOP_RD_MOD_OWN: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_op == 1'b0 && snp_hit && lines[snp_idx] == LS_MOD
         && !(cpu_valid && cpu_idx == snp_idx))
        |=> lines[$past(snp_idx)] == LS_OWN); // R7

    AST_SNOOP_WR_INVAL: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_op == 1'b1 && snp_hit && !(cpu_valid && cpu_idx == snp_idx))
        |=> lines[$past(snp_idx)] == LS_INV); // R9

    AST_SUPPLY_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        snp_supply |-> (snp_valid && snp_hit && is_dirty(snp_cur))); // R7

    AST_EVICT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_op == 2'd2 && cpu_hit) |=> lines[$past(cpu_idx)] == LS_INV); // R10

    AST_WB_ONLY_EVICT: assert property (@(posedge clk) disable iff (rst)
        writeback_req |-> (cpu_valid && cpu_op == 2'd2)); // R10

    AST_WRITE_ENDS_MOD: assert property (@(posedge clk) disable iff (rst)
        (cpu_done && cpu_op == 2'd1) |=> lines[$past(cpu_idx)] == LS_MOD); // R4

    AST_STALL_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
        (bus_req_op != 2'd0 && !bus_grant) |-> !cpu_done); // R2

endmodule

// File: tb/moesi_line_ctrl_bench.sv
module moesi_line_ctrl_bench;
    localparam int LINES = 16;
    localparam int IDX_W = $clog2(LINES);

    typedef struct packed {
        logic       cv;
        logic [1:0] cop;
        logic       chit;
        logic [3:0] cidx;
        logic       sv;
        logic       sop;
        logic       shit;
        logic [3:0] sidx;
        logic       gnt;
        logic       shr;
        logic [1:0] ereq;
        logic       esup;
        logic       ewb;
        logic       edone;
        logic [2:0] enxt;
        logic [3:0] rq;
    } vec_t;

    function automatic vec_t mk(int cv, int cop, int chit, int cidx,
                                int sv, int sop, int shit, int sidx,
                                int gnt, int shr,
                                int ereq, int esup, int ewb, int edone, int enxt, int rq);
        vec_t v;
        v.cv = cv[0];     v.cop = cop[1:0];  v.chit = chit[0]; v.cidx = cidx[3:0];
        v.sv = sv[0];     v.sop = sop[0];    v.shit = shit[0]; v.sidx = sidx[3:0];
        v.gnt = gnt[0];   v.shr = shr[0];
        v.ereq = ereq[1:0]; v.esup = esup[0]; v.ewb = ewb[0];
        v.edone = edone[0]; v.enxt = enxt[2:0]; v.rq = rq[3:0];
        return v;
    endfunction

    localparam int NV = 34;
    localparam vec_t VECS [NV] = '{
        mk(1,0,1,1, 0,0,0,0, 0,0, 1,0,0,0,0, 1),  // R1 hit on reset slot still Invalid
        mk(1,0,1,1, 0,0,0,0, 1,0, 1,0,0,1,2, 2),  // R2 fill Exclusive
        mk(1,0,1,1, 0,0,0,0, 0,0, 0,0,0,1,2, 3),  // R3 read hit
        mk(0,0,0,1, 1,0,1,1, 0,0, 0,0,0,0,1, 8),  // R8 E->S
        mk(1,1,1,1, 0,0,0,0, 0,0, 3,0,0,0,1, 5),  // R5 upgrade waits
        mk(1,1,1,1, 0,0,0,0, 1,0, 3,0,0,1,4, 5),  // R5 upgrade granted
        mk(1,1,1,1, 0,0,0,0, 0,0, 0,0,0,1,4, 4),  // R4 write on M
        mk(0,0,0,1, 1,0,1,1, 0,0, 0,1,0,0,3, 7),  // R7 M->O supply
        mk(0,0,0,1, 1,0,1,1, 0,0, 0,1,0,0,3, 7),  // R7 O stays, supply
        mk(1,1,1,1, 0,0,0,0, 1,0, 3,0,0,1,4, 5),  // R5 O upgrade
        mk(1,1,0,2, 0,0,0,0, 0,0, 2,0,0,0,0, 6),  // R6 RFO waits
        mk(1,1,0,2, 0,0,0,0, 1,0, 2,0,0,1,4, 6),  // R6 RFO granted
        mk(0,0,0,2, 1,1,1,2, 0,0, 0,1,0,0,0, 9),  // R9 snoop write on M
        mk(1,0,0,3, 0,0,0,0, 1,1, 1,0,0,1,1, 2),  // R2 fill Shared
        mk(0,0,0,3, 1,0,1,3, 0,0, 0,0,0,0,1, 8),  // R8 S no supply
        mk(0,0,0,1, 1,0,0,1, 0,0, 0,0,0,0,4, 12), // R12 snoop read miss
        mk(0,0,0,1, 1,1,0,1, 0,0, 0,0,0,0,4, 12), // R12 snoop write miss
        mk(1,2,1,1, 0,0,0,0, 0,0, 0,0,1,1,0, 10), // R10 evict M
        mk(1,2,1,3, 0,0,0,0, 0,0, 0,0,0,1,0, 10), // R10 evict S
        mk(1,2,0,3, 0,0,0,0, 0,0, 0,0,0,1,0, 10), // R10 evict miss
        mk(1,0,0,4, 0,0,0,0, 1,0, 1,0,0,1,2, 2),  // R2 fill E
        mk(1,1,1,4, 1,0,1,4, 0,0, 3,0,0,0,1, 11), // R11 snoop read then write
        mk(1,1,1,4, 1,1,1,4, 0,0, 2,0,0,0,0, 11), // R11 upgrade becomes RFO
        mk(1,1,1,4, 0,0,0,0, 1,0, 2,0,0,1,4, 6),  // R6 RFO granted
        mk(1,0,1,4, 1,0,1,4, 0,0, 0,1,0,1,3, 11), // R11 read after snoop M->O
        mk(1,2,1,4, 1,1,1,4, 0,0, 0,1,0,1,0, 11), // R11 evict after snoop write
        mk(1,0,0,5, 1,1,1,6, 1,1, 1,0,0,1,1, 2),  // R2 fill S, snoop elsewhere
        mk(1,0,1,6, 1,1,1,5, 0,0, 1,0,0,0,0, 9),  // R9 invalidate S slot 5
        mk(0,0,0,5, 0,0,0,0, 0,0, 0,0,0,0,0, 9),  // R9 slot 5 now Invalid
        mk(1,0,0,7, 0,0,0,0, 1,0, 1,0,0,1,2, 2),  // R2 fill E
        mk(1,1,1,7, 0,0,0,0, 0,0, 0,0,0,1,4, 4),  // R4 E->M silent
        mk(0,0,0,2, 1,0,1,2, 0,0, 0,0,0,0,0, 8),  // R8 snoop read on Invalid
        mk(0,0,0,7, 1,0,1,7, 0,0, 0,1,0,0,3, 7),  // R7 M->O
        mk(1,2,1,7, 0,0,0,0, 0,0, 0,0,1,1,0, 10)  // R10 evict O
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cpu_valid = 1'b0;
    logic [1:0]       cpu_op = 2'd0;
    logic             cpu_hit = 1'b0;
    logic [IDX_W-1:0] cpu_idx = '0;
    logic             snp_valid = 1'b0;
    logic             snp_op = 1'b0;
    logic             snp_hit = 1'b0;
    logic [IDX_W-1:0] snp_idx = '0;
    logic             bus_grant = 1'b0;
    logic             bus_shared = 1'b0;
    logic [1:0]       bus_req_op;
    logic             cpu_done;
    logic             writeback_req;
    logic             snp_supply;
    logic [2:0]       cpu_state_nxt;

    int applied = 0;
    int fails = 0;

    always #10 clk = ~clk;

    moesi_line_ctrl #(.LINES(LINES)) u_moesi_line_ctrl (
        .clk (clk), .rst (rst),
        .cpu_valid (cpu_valid), .cpu_op (cpu_op), .cpu_hit (cpu_hit), .cpu_idx (cpu_idx),
        .snp_valid (snp_valid), .snp_op (snp_op), .snp_hit (snp_hit), .snp_idx (snp_idx),
        .bus_grant (bus_grant), .bus_shared (bus_shared),
        .bus_req_op (bus_req_op), .cpu_done (cpu_done), .writeback_req (writeback_req),
        .snp_supply (snp_supply), .cpu_state_nxt (cpu_state_nxt)
    );

    task automatic drive(input vec_t v);
        cpu_valid = v.cv;  cpu_op = v.cop;  cpu_hit = v.chit;  cpu_idx = v.cidx;
        snp_valid = v.sv;  snp_op = v.sop;  snp_hit = v.shit;  snp_idx = v.sidx;
        bus_grant = v.gnt; bus_shared = v.shr;
    endtask

    task automatic check(input vec_t v, input int n);
        logic [7:0] act, exp;
        act = {bus_req_op, snp_supply, writeback_req, cpu_done, cpu_state_nxt};
        exp = {v.ereq, v.esup, v.ewb, v.edone, v.enxt};
        applied++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d vector %0d: req/sup/wb/done/nxt actual %b expected %b",
                     v.rq, n, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state: idle inputs give all outputs zero
        #5 check(mk(0,0,0,0, 0,0,0,0, 0,0, 0,0,0,0,0, 1), 100);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            #5 check(VECS[i], i);
        end

        // R1 reset during operation: slot 8 installed Modified, then reset
        @(negedge clk);
        drive(mk(1,1,0,8, 0,0,0,0, 1,0, 0,0,0,0,0, 6));
        #5 check(mk(1,1,0,8, 0,0,0,0, 1,0, 2,0,0,1,4, 6), 101);
        @(negedge clk);
        drive(mk(0,0,0,8, 0,0,0,0, 0,0, 0,0,0,0,0, 1));
        #5 check(mk(0,0,0,8, 0,0,0,0, 0,0, 0,0,0,0,4, 1), 102);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #5 check(mk(0,0,0,8, 0,0,0,0, 0,0, 0,0,0,0,0, 1), 103);
        // R1 snoop read after reset finds no dirty data
        @(negedge clk);
        drive(mk(0,0,0,8, 1,0,1,8, 0,0, 0,0,0,0,0, 1));
        #5 check(mk(0,0,0,8, 1,0,1,8, 0,0, 0,0,0,0,0, 1), 104);

        @(negedge clk);
        drive(mk(0,0,0,0, 0,0,0,0, 0,0, 0,0,0,0,0, 1));
        $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    end
endmodule